// File: doc/BRIEF.md
# Two-Phase Phase-Shifted PWM Timer

This block is an up-counting timer that drives two square-wave outputs with the same period and a programmable phase offset between them. Software sets a cycle compare value and a phase compare value. While the timer runs, the counter advances on each count strobe. Each output has its own toggle flop. The cycle compare inverts output A and returns the counter to zero. The phase compare inverts output B part-way through the same period. Each output therefore repeats every 2×(cycle+1) count strobes. Output B lags output A by the phase value plus one strobe.

Counting is gated by a count-strobe input, for example a divided clock, that is synchronous to the system clock. Starting the timer takes two writes. The first write sets the load bit with enable clear. This resets the counter and both toggle flops and arms the timer. The second write sets enable, and the next strobe counts. If the timer is enabled without first being armed, the first strobe is swallowed. Writes to the compare registers go to pending copies. A running timer adopts them at its next wrap. Each compare match also produces a one-clock interrupt pulse.

Top module: `pwm2ph_timer`

## Requirements
- R1: After reset the counter reads 0, both outputs and both interrupt pulses are low, and the timer is stopped.
- R2: A write to select 2 (mode) with bit 1 (load) = 1 and bit 0 (enable) = 0 clears the counter and both outputs, copies the pending compare values into use, and leaves the counter stopped.
- R3: When running and armed, each count strobe adds 1 to the counter. A strobe taken while the counter equals the cycle value (select 0) returns it to 0 and inverts out_a, so the counter runs 0 to the cycle value.
- R4: A strobe taken while the counter equals the phase value (select 1) inverts out_b, but only when the phase value is less than the cycle value. Otherwise out_b never changes.
- R5: irq_a and irq_b are high for exactly one clock: the clock after the strobe whose match they report, which is the same clock in which the matching output has inverted.
- R6: When enable is set while the timer is not armed (after reset, or after a stop), the first count strobe changes nothing and only arms the timer. Later strobes count.
- R7: A mode write with both bits 0 stops the timer. The counter and both outputs then hold through any number of strobes.
- R8: Compare writes made while running take effect at the next wrap. A cycle-value write in the same clock as the wrapping strobe takes effect at that wrap.
- R9: A strobe in the same clock as a mode write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count strobe, one clock wide, synchronous to clk |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 cycle value, 1 phase value, 2 mode |
| cfg_wdata | input | CNT_W | Write data (mode: bit 0 enable, bit 1 load) |
| count | output | CNT_W | Current counter value |
| out_a | output | 1 | Cycle-compare toggle output |
| out_b | output | 1 | Phase-compare toggle output |
| irq_a | output | 1 | Cycle-match interrupt pulse |
| irq_b | output | 1 | Phase-match interrupt pulse |

## Verification
Two events can land in the same clock: the strobe that wraps the counter and a software write to the cycle register. The bench provokes this by raising the count strobe and the write strobe together while the counter sits at the old cycle value. It judges the result by the length of the next period, which must already follow the new value. A separate case gives the phase value equal to the cycle value, so the counter reaches it, and checks that out_b and irq_b stay quiet.

// File: rtl/pwm2ph_pkg.sv
package pwm2ph_pkg;
   typedef enum logic [1:0] {
      SEL_CYC  = 2'd0,
      SEL_PHS  = 2'd1,
      SEL_MODE = 2'd2
   } reg_sel_e;

   localparam int MODE_EN_BIT = 0;
   localparam int MODE_LD_BIT = 1;
   localparam int NUM_CH      = 2;
   localparam int CH_CYC      = 0;
   localparam int CH_PHS      = 1;
endpackage

// File: rtl/pwm2ph_cfg.sv
module pwm2ph_cfg
   import pwm2ph_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] wdata,
   input  logic             arm,
   input  logic             wrap_step,
   output logic [CNT_W-1:0] cyc_act,
   output logic [CNT_W-1:0] phs_act
);
   logic [CNT_W-1:0] cyc_pend, phs_pend;
   logic [CNT_W-1:0] cyc_nxt, phs_nxt;
   logic             wr_cyc, wr_phs;

   assign wr_cyc  = wr && (sel == SEL_CYC);
   assign wr_phs  = wr && (sel == SEL_PHS);
   // a write in the wrapping clock is bypassed straight into use
   assign cyc_nxt = wr_cyc ? wdata : cyc_pend;
   assign phs_nxt = wr_phs ? wdata : phs_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_pend <= '0;
         phs_pend <= '0;
         cyc_act  <= '0;
         phs_act  <= '0;
      end else begin
         if (wr_cyc) cyc_pend <= wdata;
         if (wr_phs) phs_pend <= wdata;
         if (arm || wrap_step) begin
            cyc_act <= cyc_nxt;
            phs_act <= phs_nxt;
         end
      end
   end

   // R8
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !wrap_step) |=> ($stable(cyc_act) && $stable(phs_act)));
endmodule

// File: rtl/pwm2ph_ctrl.sv
module pwm2ph_ctrl
   import pwm2ph_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] wdata,
   input  logic             tick,
   output logic             arm,
   output logic             step
);
   logic mode_wr, en_bit, ld_bit;
   logic enabled, primed;

   assign mode_wr = wr && (sel == SEL_MODE);
   assign en_bit  = wdata[MODE_EN_BIT];
   assign ld_bit  = wdata[MODE_LD_BIT];
   assign arm     = mode_wr && ld_bit && !en_bit;
   assign step    = tick && enabled && primed && !mode_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled <= 1'b0;
         primed  <= 1'b0;
      end else if (mode_wr) begin
         enabled <= en_bit;
         if (ld_bit && !en_bit)
            primed <= 1'b1;
         else if (!ld_bit && !en_bit)
            primed <= 1'b0;
      end else if (tick && enabled && !primed) begin
         primed <= 1'b1;
      end
   end

   // R6
   swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && enabled && !primed) |-> !step);
   // R6
   prime_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && enabled && !primed && !mode_wr) |=> primed);
   // R9
   mode_wr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |-> !step);
endmodule

// File: rtl/pwm2ph_core.sv
module pwm2ph_core
   import pwm2ph_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             step,
   input  logic [CNT_W-1:0] cyc_act,
   input  logic [CNT_W-1:0] phs_act,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_step,
   output logic [NUM_CH-1:0] tgl,
   output logic [NUM_CH-1:0] irq
);
   logic [NUM_CH-1:0] hit;

   assign hit[CH_CYC] = (cnt == cyc_act);
   assign hit[CH_PHS] = (cnt == phs_act) && (phs_act < cyc_act);
   assign wrap_step   = step && hit[CH_CYC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (arm)
         cnt <= '0;
      else if (step)
         cnt <= hit[CH_CYC] ? '0 : cnt + 1'b1;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tgl[i] <= 1'b0;
            irq[i] <= 1'b0;
         end else begin
            irq[i] <= step && hit[i];
            if (arm)
               tgl[i] <= 1'b0;
            else if (step && hit[i])
               tgl[i] <= ~tgl[i];
         end
      end

      // R5
      irq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> (tgl[i] != $past(tgl[i])));
   end

   // R3
   count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !arm && (cnt != cyc_act)) |=> (cnt == $past(cnt) + 1'b1));
   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !arm && (cnt == cyc_act)) |=> ((cnt == '0) && (tgl[CH_CYC] != $past(tgl[CH_CYC]))));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !arm) |=> ($stable(cnt) && $stable(tgl)));
   // R4
   phs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[CH_PHS] |-> ($past(phs_act) < $past(cyc_act)));
endmodule

// File: rtl/pwm2ph_timer.sv
module pwm2ph_timer
   import pwm2ph_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_tick,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_sel,
   input  logic [CNT_W-1:0] cfg_wdata,
   output logic [CNT_W-1:0] count,
   output logic             out_a,
   output logic             out_b,
   output logic             irq_a,
   output logic             irq_b
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pwm2ph_timer: CNT_W must lie in 2..32");
   end

   logic             arm, step, wrap_step;
   logic [CNT_W-1:0] cyc_act, phs_act;
   logic [NUM_CH-1:0] tgl, irq;

   pwm2ph_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
      .wdata(cfg_wdata), .tick(cnt_tick), .arm(arm), .step(step)
   );

   pwm2ph_cfg #(.CNT_W(CNT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
      .wdata(cfg_wdata), .arm(arm), .wrap_step(wrap_step),
      .cyc_act(cyc_act), .phs_act(phs_act)
   );

   pwm2ph_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .arm(arm), .step(step),
      .cyc_act(cyc_act), .phs_act(phs_act), .cnt(count),
      .wrap_step(wrap_step), .tgl(tgl), .irq(irq)
   );

   assign out_a = tgl[CH_CYC];
   assign out_b = tgl[CH_PHS];
   assign irq_a = irq[CH_CYC];
   assign irq_b = irq[CH_PHS];

   // R2
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> ((count == '0) && !out_a && !out_b && !irq_a && !irq_b));
endmodule

// File: tb/tb_pwm2ph_timer.sv
module tb_pwm2ph_timer;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_tick = 1'b0;
   logic         cfg_wr = 1'b0;
   logic [1:0]   cfg_sel = 2'd0;
   logic [W-1:0] cfg_wdata = '0;
   logic [W-1:0] count;
   logic         out_a, out_b, irq_a, irq_b;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm2ph_timer #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cfg_wr(cfg_wr),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .count(count),
      .out_a(out_a), .out_b(out_b), .irq_a(irq_a), .irq_b(irq_b)
   );

   // {count, out_a, out_b, irq_a, irq_b} after each strobe, cycle 4, phase 2
   localparam logic [19:0] VEC [10] = '{
      {16'd1, 4'b0000}, {16'd2, 4'b0000}, {16'd3, 4'b0101}, {16'd4, 4'b0100},
      {16'd0, 4'b1110}, {16'd1, 4'b1100}, {16'd2, 4'b1100}, {16'd3, 4'b1001},
      {16'd4, 4'b1000}, {16'd0, 4'b0010}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic tick1();
      @(negedge clk);
      cnt_tick = 1'b1;
      @(negedge clk);
      cnt_tick = 1'b0;
   endtask

   initial begin
      logic keep_b;
      int irqb_seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 count", count, 0);
      chk("R1 outputs", {out_a, out_b, irq_a, irq_b}, 0);
      rst_n = 1'b1;
      tick1();
      chk("R1 stopped", count, 0);

      wr(2'd0, 16'd4);
      wr(2'd1, 16'd2);
      wr(2'd2, 16'h0002);
      chk("R2 armed count", count, 0);
      tick1();
      chk("R2 stays stopped", count, 0);
      wr(2'd2, 16'h0003);

      // R3 R4 R5 vector walk
      for (int k = 0; k < 10; k++) begin
         tick1();
         chk("R3 count", count, VEC[k][19:4]);
         chk("R3 R4 outputs", {out_a, out_b}, VEC[k][3:2]);
         chk("R5 irqs", {irq_a, irq_b}, VEC[k][1:0]);
      end
      @(negedge clk);
      chk("R5 single pulse", irq_a, 0);

      // R7 freeze at count 2
      tick1(); tick1();
      wr(2'd2, 16'h0000);
      for (int k = 0; k < 3; k++) tick1();
      chk("R7 count held", count, 2);
      chk("R7 outputs held", {out_a, out_b}, 2'b00);

      // R6 resume without arming: first strobe swallowed
      wr(2'd2, 16'h0001);
      tick1();
      chk("R6 swallowed", count, 2);
      chk("R6 out_b held", out_b, 0);
      tick1();
      chk("R6 counts", count, 3);
      chk("R6 out_b toggles", {out_b, irq_b}, 2'b11);

      // R8 shadow cycle value
      wr(2'd0, 16'd6);
      tick1();
      chk("R8 old cycle still used", count, 4);
      tick1();
      chk("R8 wrap at old", {count, out_a}, {16'd0, 1'b1});
      for (int k = 0; k < 6; k++) tick1();
      chk("R8 new cycle reached", count, 6);
      tick1();
      chk("R8 wrap at new", {count, out_a}, {16'd0, 1'b0});

      // R8 write coinciding with wrapping strobe
      for (int k = 0; k < 6; k++) tick1();
      @(negedge clk);
      cnt_tick = 1'b1; cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'd2;
      @(negedge clk);
      cnt_tick = 1'b0; cfg_wr = 1'b0;
      chk("R8 coincident wrap", {count, out_a}, {16'd0, 1'b1});
      tick1(); tick1();
      chk("R8 coincident new reach", count, 2);
      tick1();
      chk("R8 coincident new wrap", {count, out_a}, {16'd0, 1'b0});

      // R4 phase equal to cycle: no B activity
      keep_b = out_b;
      irqb_seen = 0;
      for (int k = 0; k < 6; k++) begin
         tick1();
         if (irq_b) irqb_seen++;
      end
      chk("R4 no irq_b when phase>=cycle", irqb_seen, 0);
      chk("R4 out_b unchanged", out_b, keep_b);

      // R9 strobe during mode write ignored
      @(negedge clk);
      cnt_tick = 1'b1; cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'h0003;
      @(negedge clk);
      cnt_tick = 1'b0; cfg_wr = 1'b0;
      chk("R9 strobe ignored", count, 0);

      // R2 re-arm with phase 0, cycle 3
      wr(2'd0, 16'd3);
      wr(2'd1, 16'd0);
      tick1();
      wr(2'd2, 16'h0002);
      chk("R2 re-arm clears", {count, out_a, out_b}, 18'd0);
      wr(2'd2, 16'h0003);
      tick1();
      chk("R4 phase 0 match", {count, out_b, irq_b}, {16'd1, 2'b11});

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule